// File: doc/BRIEF.md
# Input Range Coefficient Remapper

This block rewrites a converter's pair of self-calibration coefficients so that the converter's full code range covers a chosen input window. Normally that window is zero to the nominal span. The chosen window starts at an offset voltage and has a span scaled by a factor. Software supplies the zero-scale and full-scale coefficients from a self-calibration, the offset, the span factor, the reference voltage, the amplifier gain code and the input polarity mode. It then pulses start. After a fixed number of cycles the block presents the new zero-scale and full-scale coefficients and pulses done.

Both results come from one shared sequential restoring divider, which runs twice: once for the offset correction and once for the full-scale quotient. A single wide multiplier forms the divisor for the offset correction from the nominal span and the full-scale coefficient. The span factor is checked against a guaranteed-operation window. A factor outside that window skips the arithmetic and returns the input coefficients unchanged, with an error flag.

Top module: `rng_coef_remap`

## Requirements
- R1: After reset, `zn_out`, `fn_out`, `range_err` and `done` are all 0.
- R2: A start pulse in idle latches every operand input. Later changes on those inputs do not affect the result of that run.
- R3: The nominal span in unsigned Q4.20 is `vref_in` in unipolar mode (`bipolar`=0), or twice `vref_in` in bipolar mode. It is then shifted right by `gain_code`, where code k means gain 2^k for k = 0..7.
- R4: When the factor is in range, `zn_out` = Z0 + round(ofs·2^44 / (span·F0)), rounded half up and saturated to 2^24−1. A zero product span·F0 saturates `zn_out`.
- R5: When the factor is in range, `fn_out` = round(F0·2^20 / scale), rounded half up and saturated to 2^24−1. Here `scale_in` is unsigned Q4.20.
- R6: `scale_in` is in range when 838861 ≤ scale_in ≤ 1101004 (0.8 to 1.05 in Q4.20). Out of range, `range_err` is 1, `zn_out` equals Z0 and `fn_out` equals F0. In range, `range_err` is 0.
- R7: `done` is a one-cycle pulse. It arrives within 2·69+4 cycles of start. `zn_out`, `fn_out` and `range_err` change only together with `done` and hold until the next `done`.
- R8: A start pulse while a run is in progress is ignored. It neither alters that run's result nor produces an extra `done`.
- R9: Unipolar, span 2.5 (2621440), gain code 0, Z0 = 2165373, F0 = 5416211, ofs = 209715, scale = 1006633 gives `zn_out` = 2425218 and `fn_out` = 5641886.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run and latches the operands |
| z0_in | input | 24 | Self-calibration zero-scale coefficient |
| f0_in | input | 24 | Self-calibration full-scale coefficient |
| ofs_in | input | 24 | Range offset voltage, unsigned Q4.20 |
| scale_in | input | 24 | Span scale factor, unsigned Q4.20 |
| vref_in | input | 24 | Reference voltage, unsigned Q4.20 |
| gain_code | input | 3 | Amplifier gain as a power-of-two exponent |
| bipolar | input | 1 | 1 selects bipolar input range |
| zn_out | output | 24 | New zero-scale coefficient |
| fn_out | output | 24 | New full-scale coefficient |
| range_err | output | 1 | Scale factor outside the allowed window |
| done | output | 1 | One-cycle result-ready pulse |

## Verification
On every cycle, the in-RTL assertions check the handshake and the holding behaviour. They confirm that `done` lasts one cycle and that the outputs move only with it. They confirm that the error flag agrees with the independent window check, and that an error result returns the latched input coefficients. They also confirm that a start pulse mid-run leaves the latched operands untouched and that the divider is launched only when idle. The numeric results of the offset correction and the full-scale quotient can only be shown by the bench's scenarios: rounding, saturation of both outputs, a zero divisor, bipolar and high-gain spans, the window edges and the known check vector.

// File: rtl/rng_remap_pkg.sv
package rng_remap_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHK,
      ST_ZDIV,
      ST_FDIV
   } remap_state_e;

endpackage

// File: rtl/rng_span_mul.sv
module rng_span_mul #(
   parameter int QW = 24,
   parameter int CW = 24,
   parameter int GW = 3,
   parameter int DW = 69
) (
   input  logic [QW-1:0] vref,
   input  logic [GW-1:0] gain,
   input  logic          bip,
   input  logic [CW-1:0] fs_coef,
   output logic [DW-1:0] prod
);
   localparam int SW = QW + 1;

   logic [SW-1:0] ref_x;
   logic [SW-1:0] span;

   generate
      if (DW < SW + CW) begin : g_bad
         $error("rng_span_mul: DW too narrow for span product");
      end
   endgenerate

   // bipolar doubles the nominal span before the gain shift
   assign ref_x = bip ? {vref, 1'b0} : {1'b0, vref};
   assign span  = ref_x >> gain;
   assign prod  = DW'(span) * DW'(fs_coef);

endmodule

// File: rtl/rng_window.sv
module rng_window #(
   parameter int QW    = 24,
   parameter int A_MIN = 838861,
   parameter int A_MAX = 1101004
) (
   input  logic [QW-1:0] factor,
   output logic          in_win
);
   generate
      if (A_MIN > A_MAX) begin : g_bad
         $error("rng_window: empty window");
      end
   endgenerate

   assign in_win = (factor >= QW'(A_MIN)) && (factor <= QW'(A_MAX));

endmodule

// File: rtl/rng_divider.sv
module rng_divider #(
   parameter int W = 69
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] quo
);
   localparam int CNTW = $clog2(W);

   logic [W-1:0]    q_r;
   logic [W-1:0]    r_r;
   logic [W-1:0]    d_r;
   logic [CNTW-1:0] cnt;
   logic [W:0]      shifted;
   logic [W:0]      diff;
   logic            ge;

   assign shifted = {r_r, q_r[W-1]};
   assign ge      = shifted >= {1'b0, d_r};
   assign diff    = shifted - {1'b0, d_r};
   assign quo     = q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r  <= '0;
         r_r  <= '0;
         d_r  <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            q_r  <= num;
            r_r  <= '0;
            d_r  <= den;
            cnt  <= '0;
            busy <= 1'b1;
         end else if (busy) begin
            q_r <= {q_r[W-2:0], ge};
            r_r <= ge ? diff[W-1:0] : shifted[W-1:0];
            cnt <= cnt + 1'b1;
            if (cnt == CNTW'(W - 1)) begin
               busy <= 1'b0;
               fin  <= 1'b1;
            end
         end
      end
   end

   // R7
   fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);

   // R4
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && d_r != '0) |-> (r_r < d_r));

endmodule

// File: rtl/rng_coef_remap.sv
module rng_coef_remap #(
   parameter int CW            = 24,
   parameter int QW            = 24,
   parameter int FRAC          = 20,
   parameter int GW            = 3,
   parameter int ZSH           = 44,
   parameter int A_MIN         = 838861,
   parameter int A_MAX         = 1101004,
   parameter int ROUND_NEAREST = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] z0_in,
   input  logic [CW-1:0] f0_in,
   input  logic [QW-1:0] ofs_in,
   input  logic [QW-1:0] scale_in,
   input  logic [QW-1:0] vref_in,
   input  logic [GW-1:0] gain_code,
   input  logic          bipolar,
   output logic [CW-1:0] zn_out,
   output logic [CW-1:0] fn_out,
   output logic          range_err,
   output logic          done
);
   import rng_remap_pkg::*;

   localparam int DW = QW + ZSH + 1;
   localparam logic [CW-1:0] CMAX = '1;

   generate
      if (DW < 64) begin : g_bad_dw
         $error("rng_coef_remap: intermediate width below 64 bits");
      end
      if (CW + FRAC + 1 > DW) begin : g_bad_fn
         $error("rng_coef_remap: full-scale numerator too wide");
      end
      if ((1 << GW) - 1 > QW) begin : g_bad_gw
         $error("rng_coef_remap: gain shift exceeds span width");
      end
   endgenerate

   remap_state_e  state;
   logic [CW-1:0] z0_q, f0_q, zs_q;
   logic [QW-1:0] b_q, a_q, vref_q;
   logic [GW-1:0] g_q;
   logic          bip_q;

   logic          a_ok;
   logic [DW-1:0] den_z, bias_z, bias_f, num_z, num_f;
   logic [DW-1:0] div_num, div_den, div_quo;
   logic          div_go, div_busy, div_fin;
   logic [DW:0]   zsum;
   logic [CW-1:0] zsat, fsat;

   rng_span_mul #(.QW(QW), .CW(CW), .GW(GW), .DW(DW)) i_span (
      .vref    (vref_q),
      .gain    (g_q),
      .bip     (bip_q),
      .fs_coef (f0_q),
      .prod    (den_z)
   );

   rng_window #(.QW(QW), .A_MIN(A_MIN), .A_MAX(A_MAX)) i_win (
      .factor (a_q),
      .in_win (a_ok)
   );

   generate
      if (ROUND_NEAREST != 0) begin : g_rnd
         assign bias_z = den_z >> 1;
         assign bias_f = DW'(a_q) >> 1;
      end else begin : g_trunc
         assign bias_z = '0;
         assign bias_f = '0;
      end
   endgenerate

   assign num_z   = (DW'(b_q) << ZSH) + bias_z;
   assign num_f   = (DW'(f0_q) << FRAC) + bias_f;
   assign div_num = (state == ST_CHK) ? num_z : num_f;
   assign div_den = (state == ST_CHK) ? den_z : DW'(a_q);
   assign div_go  = ((state == ST_CHK) && a_ok) ||
                    ((state == ST_ZDIV) && div_fin);

   rng_divider #(.W(DW)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   (div_num),
      .den   (div_den),
      .busy  (div_busy),
      .fin   (div_fin),
      .quo   (div_quo)
   );

   assign zsum = (DW+1)'(z0_q) + {1'b0, div_quo};
   assign zsat = (zsum > (DW+1)'(CMAX)) ? CMAX : zsum[CW-1:0];
   assign fsat = (div_quo > DW'(CMAX)) ? CMAX : div_quo[CW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         z0_q      <= '0;
         f0_q      <= '0;
         zs_q      <= '0;
         b_q       <= '0;
         a_q       <= '0;
         vref_q    <= '0;
         g_q       <= '0;
         bip_q     <= 1'b0;
         zn_out    <= '0;
         fn_out    <= '0;
         range_err <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  z0_q   <= z0_in;
                  f0_q   <= f0_in;
                  b_q    <= ofs_in;
                  a_q    <= scale_in;
                  vref_q <= vref_in;
                  g_q    <= gain_code;
                  bip_q  <= bipolar;
                  state  <= ST_CHK;
               end
            end
            ST_CHK: begin
               if (!a_ok) begin
                  zn_out    <= z0_q;
                  fn_out    <= f0_q;
                  range_err <= 1'b1;
                  done      <= 1'b1;
                  state     <= ST_IDLE;
               end else begin
                  state <= ST_ZDIV;
               end
            end
            ST_ZDIV: begin
               if (div_fin) begin
                  zs_q  <= zsat;
                  state <= ST_FDIV;
               end
            end
            ST_FDIV: begin
               if (div_fin) begin
                  zn_out    <= zs_q;
                  fn_out    <= fsat;
                  range_err <= 1'b0;
                  done      <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(zn_out) && $stable(fn_out) && $stable(range_err)));

   // R6
   err_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (range_err == !a_ok));

   // R6
   err_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && range_err) |-> (zn_out == z0_q && fn_out == f0_q));

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start) |=> ($stable(z0_q) && $stable(a_q) && $stable(b_q)));

   // R8
   div_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_go |-> !div_busy);

endmodule

// File: tb/test_rng_coef_remap.sv
module test_rng_coef_remap;
   localparam int DW  = 69;
   localparam int LAT = 2 * DW + 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] z0_in = '0, f0_in = '0, ofs_in = '0, scale_in = '0, vref_in = '0;
   logic [2:0]  gain_code = '0;
   logic        bipolar = 1'b0;
   logic [23:0] zn_out, fn_out;
   logic        range_err, done;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   rng_coef_remap i_rng_coef_remap (
      .clk(clk), .rst_n(rst_n), .start(start),
      .z0_in(z0_in), .f0_in(f0_in), .ofs_in(ofs_in), .scale_in(scale_in),
      .vref_in(vref_in), .gain_code(gain_code), .bipolar(bipolar),
      .zn_out(zn_out), .fn_out(fn_out), .range_err(range_err), .done(done)
   );

   function automatic logic exp_err(input logic [23:0] a);
      return (a < 24'd838861) || (a > 24'd1101004);
   endfunction

   function automatic logic [23:0] exp_zn(input logic [23:0] z0, f0, b, a, vref,
                                          input logic [2:0] g, input logic bip);
      logic [127:0] sp, den, q, s;
      if (exp_err(a)) return z0;
      sp  = bip ? (128'(vref) << 1) : 128'(vref);
      sp  = sp >> g;
      den = sp * 128'(f0);
      if (den == 0) return 24'hFFFFFF;
      q = ((128'(b) << 44) + (den >> 1)) / den;
      s = 128'(z0) + q;
      return (s > 128'h00FF_FFFF) ? 24'hFFFFFF : s[23:0];
   endfunction

   function automatic logic [23:0] exp_fn(input logic [23:0] f0, a);
      logic [127:0] q;
      if (exp_err(a)) return f0;
      q = ((128'(f0) << 20) + (128'(a) >> 1)) / 128'(a);
      return (q > 128'h00FF_FFFF) ? 24'hFFFFFF : q[23:0];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic scramble();
      z0_in = 24'($urandom); f0_in = 24'($urandom); ofs_in = 24'($urandom);
      scale_in = 24'($urandom); vref_in = 24'($urandom);
      gain_code = 3'($urandom); bipolar = 1'($urandom);
   endtask

   // waits for done; returns 1 if seen within the latency bound (R7)
   task automatic wait_done(output bit seen);
      seen = 0;
      for (int i = 0; i < LAT; i++) begin
         if (done) begin seen = 1; break; end
         @(negedge clk);
      end
      checks++;
      if (!seen) begin
         fails++;
         $display("FAIL R7 done missing actual=0 expected=1");
      end
   endtask

   task automatic run(input logic [23:0] z0, f0, b, a, vref,
                      input logic [2:0] g, input logic bip, input string tag);
      logic [23:0] ez, ef;
      logic        ee;
      bit          seen;
      ez = exp_zn(z0, f0, b, a, vref, g, bip);
      ef = exp_fn(f0, a);
      ee = exp_err(a);
      z0_in = z0; f0_in = f0; ofs_in = b; scale_in = a; vref_in = vref;
      gain_code = g; bipolar = bip;
      pulse_start();
      scramble(); // R2: inputs after start must not matter
      wait_done(seen);
      if (seen) begin
         check({tag, " R4 zn"}, 64'(zn_out), 64'(ez));
         check({tag, " R5 fn"}, 64'(fn_out), 64'(ef));
         check({tag, " R6 err"}, 64'(range_err), 64'(ee));
         @(negedge clk);
         check({tag, " R7 done width"}, 64'(done), 64'd0);
         check({tag, " R7 hold zn"}, 64'(zn_out), 64'(ez));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      bit seen;
      void'($urandom(32'h1bad_5eed));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 zn", 64'(zn_out), 0);
      check("R1 fn", 64'(fn_out), 0);
      check("R1 err", 64'(range_err), 0);
      check("R1 done", 64'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 known vector, also against literals
      run(24'd2165373, 24'd5416211, 24'd209715, 24'd1006633, 24'd2621440, 3'd0, 1'b0, "R9 vec");
      check("R9 zn literal", 64'(zn_out), 64'd2425218);
      check("R9 fn literal", 64'(fn_out), 64'd5641886);

      // R6 window edges
      run(24'd1000, 24'd4000000, 24'd100000, 24'd838860, 24'd2621440, 3'd0, 1'b0, "R6 below");
      run(24'd1000, 24'd4000000, 24'd100000, 24'd838861, 24'd2621440, 3'd0, 1'b0, "R6 low edge");
      run(24'd1000, 24'd4000000, 24'd100000, 24'd1101004, 24'd2621440, 3'd0, 1'b0, "R6 high edge");
      run(24'd77, 24'd4000000, 24'd100000, 24'd1101005, 24'd2621440, 3'd0, 1'b0, "R6 above");
      run(24'd77, 24'd4000000, 24'd100000, 24'd0, 24'd2621440, 3'd0, 1'b0, "R6 zero");

      // R3 bipolar and gain shifts
      run(24'd2000000, 24'd5000000, 24'd300000, 24'd1048576, 24'd2621440, 3'd0, 1'b1, "R3 bip");
      run(24'd2000000, 24'd5000000, 24'd30000, 24'd1048576, 24'd2621440, 3'd3, 1'b0, "R3 g8");
      run(24'd2000000, 24'd5000000, 24'd3000, 24'd1048576, 24'd2621440, 3'd7, 1'b1, "R3 g128");

      // R5 full-scale saturation, R4 offset saturation and zero divisor
      run(24'd5, 24'hFFFFFF, 24'd0, 24'd838861, 24'd2621440, 3'd0, 1'b0, "R5 sat");
      run(24'hFFFF00, 24'd5000000, 24'hFFFFFF, 24'd1048576, 24'd1000, 3'd7, 1'b0, "R4 sat");
      run(24'd1234, 24'd5000000, 24'd100, 24'd1048576, 24'd0, 3'd0, 1'b0, "R4 zero den");

      // R8 start during a run is ignored
      z0_in = 24'd2165373; f0_in = 24'd5416211; ofs_in = 24'd209715;
      scale_in = 24'd1006633; vref_in = 24'd2621440; gain_code = 3'd0; bipolar = 1'b0;
      pulse_start();
      repeat (20) @(negedge clk);
      scale_in = 24'd1; z0_in = 24'd9;
      pulse_start();
      wait_done(seen);
      check("R8 zn", 64'(zn_out), 64'd2425218);
      check("R8 err", 64'(range_err), 0);
      begin
         int extra = 0;
         for (int i = 0; i < LAT + 10; i++) begin
            @(negedge clk);
            if (done) extra++;
         end
         check("R8 no extra done", 64'(extra), 0);
      end

      // random vectors, mostly inside the window
      for (int n = 0; n < 40; n++) begin
         logic [23:0] a;
         if ($urandom % 5 == 0) a = 24'($urandom);
         else a = 24'(838861 + ($urandom % (1101004 - 838861 + 1)));
         run(24'($urandom), 24'($urandom), 24'($urandom % 24'h300000), a,
             24'($urandom % 24'h500000), 3'($urandom), 1'($urandom), "R4 R5 rand");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule